// File: doc/BRIEF.md
# VRAM Block DMA Controller

This block copies data from a 16-bit system address space into an 8 KiB video memory window. It moves the data in 16-byte blocks. Software programs a source address, a destination offset and a block count through five byte-wide registers, then picks one of two modes.

In general mode every block is copied back to back, and the processor is held by a stall output until the last byte has landed. In blank-paced mode the request waits until the display is enabled. After that, exactly one block is copied on each rising edge of horizontal blank during visible lines. Software can stop a paced transfer partway through.

Each byte takes two clocks: a read cycle on the memory master port, then a write cycle that forwards the returned byte into the video window. A status readback reports whether a transfer is running and how many blocks remain.

Top module: `vram_block_dma`

## Requirements
- R1: After reset, reading register 4 returns 0xFF until the first write to register 4. No stall and no memory access occur after reset.
- R2: The source address is 16 bits. Register 0 sets address bits 15..8, register 1 bits 7..4 set address bits 7..4, and the low 4 address bits are always zero.
- R3: The destination is a 13-bit offset. Bits 4..0 of register 2 set offset bits 12..8, bits 7..4 of register 3 set offset bits 7..4, and the low 4 offset bits are zero. The write address is 0x8000 plus the offset.
- R4: A block is 16 bytes, copied in ascending order. Each byte is a read cycle followed by a write cycle in the next clock, and the write carries the byte returned for that read. After each block, source and destination both advance by 16.
- R5: A write to register 4 with bit 7 = 0 while no paced transfer is active starts general mode. It copies (bits 6..0)+1 blocks back to back. The stall output is high from the clock after the write until the final byte is written.
- R6: Reading register 4 returns bit 7 = 0 with the remaining 0-based count while a transfer is active, and bit 7 = 1 with the count while inactive. A completed transfer reads 0x80.
- R7: A write to register 4 with bit 7 = 1 requests paced mode and loads the count. The request stays pending (status bit 7 = 1) and copies nothing until the display-enable input is high.
- R8: An active paced transfer copies one block per rising edge of the horizontal-blank input, but only when the line number is below 144. At most one block is copied per blank, however long the blank lasts. Each block decrements the count, and the block copied with the count at 0 ends the transfer.
- R9: A write to register 4 with bit 7 = 0 during an active paced transfer cancels it. The written count is still loaded, so the status reads 0x80 plus that count, and later blanks copy nothing.
- R10: Writing offset 0x1FFF ends the transfer with the count forced to 0. The destination offset wraps to 0 and the source advances past the bytes written.
- R11: The remaining count changes only on a register 4 write or by decrementing at a block end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 3 | Register index: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control/status |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Status when index is 4, otherwise 0xFF |
| cpu_stall | output | 1 | Processor hold during general mode |
| mem_rd_en | output | 1 | Read cycle strobe |
| mem_rd_addr | output | 16 | Read byte address |
| mem_rd_data | input | 8 | Read data, valid the clock after the strobe |
| mem_wr_en | output | 1 | Video write strobe |
| mem_wr_addr | output | 16 | Video write byte address |
| mem_wr_data | output | 8 | Video write data |
| line_num | input | LINE_W | Current display line |
| hblank | input | 1 | Horizontal blank level |
| disp_en | input | 1 | Display enable |

## Verification
The assertions take for granted that the memory returns read data on the clock after a read strobe. They also assume that the line number and display enable are steady around a blank edge, and that no paced cancel lands in the middle of a block.

The stimulus follows these assumptions. It holds the line number fixed for a whole blank pulse. It waits two clocks after any enable or request before raising blank, so the pending-to-active step has already happened. It issues a cancel only after the current block has finished.

// File: rtl/vram_block_dma.sv
module vram_block_dma #(
  parameter int          LINE_W        = 8,
  parameter int          VISIBLE_LINES = 144,
  parameter logic [2:0]  WIN_TOP       = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cpu_sel,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_rd_en,
  output logic [15:0]       mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [15:0]       mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  input  logic [LINE_W-1:0] line_num,
  input  logic              hblank,
  input  logic              disp_en
);

  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;
  localparam logic [LINE_W-1:0] VIS = LINE_W'(VISIBLE_LINES);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_t;

  st_t        st_q;
  logic [11:0] src_q;
  logic [8:0]  dst_q;
  logic [6:0]  cnt_q;
  logic [3:0]  idx_q;
  logic        active_q, paced_q, pend_q, fresh_q, hb_q;

  logic bus_ok, ctrl_wr, cancel, blk_go, blk_end, win_end;

  assign cpu_stall = active_q && !paced_q;
  assign bus_ok    = cpu_wr && !cpu_stall;
  assign ctrl_wr   = bus_ok && (cpu_sel == SEL_CTRL);
  assign cancel    = ctrl_wr && !cpu_wdata[7] && active_q && paced_q;
  assign blk_go    = (st_q == ST_IDLE) && active_q && paced_q && disp_en &&
                     hblank && !hb_q && (line_num < VIS);
  assign blk_end   = (st_q == ST_WR) && (idx_q == 4'hF);
  assign win_end   = (dst_q == 9'h1FF);

  assign mem_rd_en   = (st_q == ST_RD);
  assign mem_rd_addr = {src_q, idx_q};
  assign mem_wr_en   = (st_q == ST_WR);
  assign mem_wr_addr = {WIN_TOP, dst_q, idx_q};
  assign mem_wr_data = mem_rd_data;

  assign cpu_rdata = (cpu_sel != SEL_CTRL) ? 8'hFF :
                     fresh_q ? 8'hFF : {!active_q, cnt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      paced_q  <= 1'b0;
      pend_q   <= 1'b0;
      fresh_q  <= 1'b1;
      hb_q     <= 1'b0;
    end else begin
      hb_q <= hblank;

      if (bus_ok && cpu_sel == SEL_SRC_HI) src_q[11:4] <= cpu_wdata;
      if (bus_ok && cpu_sel == SEL_SRC_LO) src_q[3:0]  <= cpu_wdata[7:4];
      if (bus_ok && cpu_sel == SEL_DST_HI) dst_q[8:4]  <= cpu_wdata[4:0];
      if (bus_ok && cpu_sel == SEL_DST_LO) dst_q[3:0]  <= cpu_wdata[7:4];

      if (pend_q && disp_en) begin
        active_q <= 1'b1;
        pend_q   <= 1'b0;
      end

      case (st_q)
        ST_IDLE: if (blk_go) begin
          st_q  <= ST_RD;
          idx_q <= '0;
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          if (blk_end) begin
            src_q <= src_q + 12'd1;
            dst_q <= dst_q + 9'd1;
            idx_q <= '0;
            if (win_end || cnt_q == 7'd0) begin
              active_q <= 1'b0;
              pend_q   <= 1'b0;
              cnt_q    <= '0;
              st_q     <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q - 7'd1;
              st_q  <= paced_q ? ST_IDLE : ST_RD;
            end
          end else begin
            idx_q <= idx_q + 4'd1;
            st_q  <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase

      if (ctrl_wr) begin
        fresh_q <= 1'b0;
        cnt_q   <= cpu_wdata[6:0];
        if (cancel) begin
          active_q <= 1'b0;
          pend_q   <= 1'b0;
          st_q     <= ST_IDLE;
        end else if (cpu_wdata[7]) begin
          paced_q <= 1'b1;
          pend_q  <= 1'b1;
        end else begin
          paced_q  <= 1'b0;
          pend_q   <= 1'b0;
          active_q <= 1'b1;
          st_q     <= ST_RD;
          idx_q    <= '0;
        end
      end
    end
  end

  assert_rd_then_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !cancel) |=> mem_wr_en);

  assert_wr_follows_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wr_addr[3:0] == $past(mem_rd_addr[3:0]) && $past(mem_rd_en)));

  assert_stall_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> mem_rd_en);

  assert_paced_start_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && paced_q && $past(st_q) == ST_IDLE) |-> ($past(hblank) && !$past(hb_q)));

  assert_cancel_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!active_q && !pend_q && !mem_rd_en && !mem_wr_en));

  assert_count_moves_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctrl_wr) && cnt_q != $past(cnt_q)) |-> (cnt_q < $past(cnt_q)));

endmodule

// File: tb/vram_block_dma_tb.sv
module vram_block_dma_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cpu_sel = 3'd4;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_stall;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_rd_data = '0;
  logic [7:0]  mem_wr_data;
  logic [7:0]  line_num = '0;
  logic        hblank = 1'b0;
  logic        disp_en = 1'b0;

  int total = 0;
  int bad = 0;
  logic [23:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_block_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .line_num(line_num), .hblank(hblank), .disp_en(disp_en)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      logic [23:0] e;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected write: got %h=%h expected none", mem_wr_addr, mem_wr_data);
      end else begin
        e = exp_q.pop_front();
        if ({mem_wr_addr, mem_wr_data} !== e) begin
          bad++;
          $display("FAIL R4 write: got %h=%h expected %h=%h",
                   mem_wr_addr, mem_wr_data, e[23:8], e[7:0]);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect_block(input logic [15:0] src, input logic [12:0] off);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] s;
      logic [15:0] d;
      s = src + 16'(i);
      d = 16'h8000 + {3'b000, off} + 16'(i);
      exp_q.push_back({d, pat(s)});
    end
  endtask

  task automatic bus_wr(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    cpu_sel = sel; cpu_wdata = data; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_sel = 3'd4;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && cpu_stall; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] ln, input int len);
    repeat (2) @(negedge clk);
    line_num = ln; hblank = 1'b1;
    repeat (len) @(negedge clk);
    hblank = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 fresh status", cpu_rdata, 8'hFF);
    check("R1 no stall", {7'd0, cpu_stall}, 8'h00);

    // R2 R3 R5: general mode, masked addresses, two blocks
    bus_wr(3'd0, 8'h12); bus_wr(3'd1, 8'h3F);
    bus_wr(3'd2, 8'h9F); bus_wr(3'd3, 8'hAB);
    expect_block(16'h1230, 13'h1FA0);
    expect_block(16'h1240, 13'h1FB0);
    bus_wr(3'd4, 8'h01);
    check("R5 stall high", {7'd0, cpu_stall}, 8'h01);
    check("R6 active status", cpu_rdata, 8'h01);
    wait_idle();
    check("R5 stall released", {7'd0, cpu_stall}, 8'h00);
    check("R6 done status", cpu_rdata, 8'h80);

    // R10: window end stops a six-block request after two blocks
    bus_wr(3'd0, 8'h40); bus_wr(3'd1, 8'h00);
    bus_wr(3'd2, 8'h1F); bus_wr(3'd3, 8'hE0);
    expect_block(16'h4000, 13'h1FE0);
    expect_block(16'h4010, 13'h1FF0);
    bus_wr(3'd4, 8'h05);
    wait_idle();
    check("R10 forced complete", cpu_rdata, 8'h80);
    check("R10 queue drained", 8'(exp_q.size()), 8'h00);
    expect_block(16'h4020, 13'h0000);
    bus_wr(3'd4, 8'h00);
    wait_idle();
    check("R10 wrapped follow-on", cpu_rdata, 8'h80);

    // R7 R8: paced mode
    bus_wr(3'd0, 8'h20); bus_wr(3'd1, 8'h00);
    bus_wr(3'd2, 8'h01); bus_wr(3'd3, 8'h00);
    bus_wr(3'd4, 8'h82);
    check("R7 pending status", cpu_rdata, 8'h82);
    check("R7 no stall", {7'd0, cpu_stall}, 8'h00);
    pulse(8'd10, 5);
    check("R7 no copy while display off", cpu_rdata, 8'h82);
    disp_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 active once enabled", cpu_rdata, 8'h02);
    expect_block(16'h2000, 13'h0100);
    pulse(8'd10, 50);
    check("R8 one block per long blank", cpu_rdata, 8'h01);
    pulse(8'd150, 5);
    check("R8 no copy below visible area", cpu_rdata, 8'h01);
    expect_block(16'h2010, 13'h0110);
    pulse(8'd0, 5);
    check("R8 last block pending", cpu_rdata, 8'h00);
    expect_block(16'h2020, 13'h0120);
    pulse(8'd143, 5);
    check("R8 paced complete", cpu_rdata, 8'h80);

    // R9: cancel
    bus_wr(3'd4, 8'h85);
    expect_block(16'h2030, 13'h0130);
    pulse(8'd20, 5);
    check("R9 before cancel", cpu_rdata, 8'h04);
    bus_wr(3'd4, 8'h03);
    check("R9 cancel status", cpu_rdata, 8'h83);
    pulse(8'd20, 5);
    check("R9 no copy after cancel", cpu_rdata, 8'h83);

    // R5: general start after cancel
    expect_block(16'h2040, 13'h0140);
    bus_wr(3'd4, 8'h00);
    wait_idle();
    check("R5 general after cancel", cpu_rdata, 8'h80);
    check("R4 all writes seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule